// File: doc/BRIEF.md
# Interrupt Destination Resolver and Dispatcher

This block accepts one interrupt delivery request at a time and turns it into a stream of per-CPU deliveries. A request carries an 8-bit destination, a mode bit that selects physical or logical addressing, a 3-bit delivery mode and an 8-bit vector. Each CPU in the system is described by three inputs: a present flag, an 8-bit physical ID and an 8-bit logical ID. From these the block resolves a bitmask of target CPUs in the cycle the request is accepted.

The block then delivers the vector to the resolved targets. It emits one target index per clock with a valid strobe and holds the vector steady alongside it. Fixed delivery reaches every CPU in the mask. Lowest-priority delivery reaches a single CPU, chosen by a round-robin pointer that persists across requests. Any other delivery mode is discarded. While a dispatch is in progress, `req_ready` is low and new requests are not taken.

Top module: `irq_dispatch_top`

## Requirements
- R1: After reset `out_valid` is 0 and `req_ready` is 1.
- R2: A physical-mode request (`req_logical`=0) with destination 0xFF selects every CPU whose present flag is set.
- R3: A physical-mode request with any other destination selects only the lowest-index present CPU whose physical ID equals the destination, even when higher-index CPUs share that ID.
- R4: A logical-mode request (`req_logical`=1) with destination 0 selects no CPU.
- R5: A logical-mode request with a nonzero destination selects every present CPU whose logical ID has at least one set bit in common with the destination.
- R6: When the resolved mask is empty, nothing is delivered and `req_ready` stays 1.
- R7: Fixed delivery (mode 3'b000) drives `out_valid` high for one cycle per selected CPU. These cycles are consecutive and begin in the cycle after acceptance. Targets appear in ascending index order, and `out_vector` equals the request vector throughout.
- R8: Lowest-priority delivery (mode 3'b001) delivers exactly once. The target is the first selected CPU found by searching upward from the index after the previously chosen CPU, wrapping at the top. After reset the search starts at index 0. Only lowest-priority deliveries move the pointer.
- R9: Any delivery mode other than 3'b000 and 3'b001 produces no delivery.
- R10: A request is accepted only when `req_valid` and `req_ready` are both 1. `req_ready` is 0 in every cycle with `out_valid` high, and requests offered during a dispatch are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and can accept a request |
| req_dest | input | 8 | Destination field |
| req_logical | input | 1 | 1 = logical addressing, 0 = physical |
| req_mode | input | 3 | Delivery mode: 000 fixed, 001 lowest priority |
| req_vector | input | 8 | Interrupt vector |
| cpu_present | input | NCPU | Present flag per CPU |
| cpu_phys_id | input | NCPU*8 | Physical ID per CPU, CPU i in bits [8i+7:8i] |
| cpu_log_id | input | NCPU*8 | Logical ID per CPU, CPU i in bits [8i+7:8i] |
| out_valid | output | 1 | A delivery is presented this cycle |
| out_target | output | clog2(NCPU) | Index of the CPU receiving the delivery |
| out_vector | output | 8 | Vector being delivered |

## Verification
The bench builds the block with the default of eight CPUs. Eight CPUs are enough to produce multi-target fixed bursts of up to eight cycles and a full wrap of the round-robin pointer past index 7. Random physical IDs drawn from only four values force duplicate IDs, so the first-match rule is exercised, and random logical IDs give overlapping logical matches.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int DEST_W = 8;
    localparam int VEC_W  = 8;
    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] MODE_FIXED  = 3'b000;
    localparam logic [MODE_W-1:0] MODE_LOWEST = 3'b001;
    localparam logic [DEST_W-1:0] DEST_ALL    = '1;

    typedef enum logic {ADDR_PHYS = 1'b0, ADDR_LOGIC = 1'b1} addr_kind_e;

    typedef struct packed {
        logic [VEC_W-1:0]  vector;
        logic [MODE_W-1:0] mode;
    } job_t;

    function automatic logic mode_supported(input logic [MODE_W-1:0] m);
        return (m == MODE_FIXED) || (m == MODE_LOWEST);
    endfunction

endpackage

// File: rtl/irq_dest_resolve.sv
module irq_dest_resolve
    import irq_route_pkg::*;
#(
    parameter int NCPU = 8
) (
    input  logic [DEST_W-1:0]      dest,
    input  addr_kind_e             kind,
    input  logic [NCPU-1:0]        present,
    input  logic [NCPU*DEST_W-1:0] phys_ids,
    input  logic [NCPU*DEST_W-1:0] log_ids,
    output logic [NCPU-1:0]        mask
);

    logic [NCPU-1:0] phys_hit;
    logic [NCPU-1:0] log_hit;

    genvar g;
    generate
        for (g = 0; g < NCPU; g++) begin : g_cmp
            assign phys_hit[g] = present[g] && (phys_ids[g*DEST_W +: DEST_W] == dest);
            assign log_hit[g]  = present[g] && (|(log_ids[g*DEST_W +: DEST_W] & dest));
        end
    endgenerate

    logic [NCPU-1:0] first_phys;
    always_comb begin
        first_phys = '0;
        for (int i = NCPU - 1; i >= 0; i--) begin
            if (phys_hit[i]) begin
                first_phys    = '0;
                first_phys[i] = 1'b1;
            end
        end
    end

    always_comb begin
        if (kind == ADDR_PHYS) begin
            mask = (dest == DEST_ALL) ? present : first_phys;
        end else begin
            mask = (dest == '0) ? '0 : log_hit;
        end
    end

endmodule

// File: rtl/irq_rr_pick.sv
module irq_rr_pick #(
    parameter int NCPU = 8,
    localparam int IDX_W = $clog2(NCPU)
) (
    input  logic [NCPU-1:0]  mask,
    input  logic [IDX_W-1:0] last,
    output logic [IDX_W-1:0] pick,
    output logic             pick_ok
);

    always_comb begin
        pick    = '0;
        pick_ok = 1'b0;
        for (int off = 1; off <= NCPU; off++) begin
            int j;
            j = int'(last) + off;
            if (j >= NCPU) j = j - NCPU;
            if (!pick_ok && mask[j]) begin
                pick    = IDX_W'(j);
                pick_ok = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_dispatch_seq.sv
module irq_dispatch_seq
    import irq_route_pkg::*;
#(
    parameter int NCPU = 8,
    localparam int IDX_W = $clog2(NCPU)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  job_t             job,
    input  logic [NCPU-1:0]  mask,
    input  logic [IDX_W-1:0] pick,
    input  logic             pick_ok,
    output logic [IDX_W-1:0] last,
    output logic             ready,
    output logic             out_valid,
    output logic [IDX_W-1:0] out_target,
    output logic [VEC_W-1:0] out_vector
);

    logic [NCPU-1:0]  pending;
    logic [VEC_W-1:0] vec_q;

    always_comb begin
        out_target = '0;
        for (int i = NCPU - 1; i >= 0; i--) begin
            if (pending[i]) out_target = IDX_W'(i);
        end
    end

    assign out_valid  = |pending;
    assign ready      = ~out_valid;
    assign out_vector = vec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
            vec_q   <= '0;
            last    <= IDX_W'(NCPU - 1);
        end else if (accept) begin
            vec_q <= job.vector;
            case (job.mode)
                MODE_FIXED:  pending <= mask;
                MODE_LOWEST: begin
                    if (pick_ok) begin
                        pending       <= '0;
                        pending[pick] <= 1'b1;
                        last          <= pick;
                    end else begin
                        pending <= '0;
                    end
                end
                default:     pending <= '0;
            endcase
        end else if (out_valid) begin
            pending[out_target] <= 1'b0;
        end
    end

    assert_ascending_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid)) |-> (out_target > $past(out_target)));

    assert_vector_held_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid)) |-> $stable(out_vector));

    assert_empty_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (accept && mask == '0) |=> (!out_valid && ready));

    assert_lowest_single_R8: assert property (@(posedge clk) disable iff (rst)
        (accept && job.mode == MODE_LOWEST && mask != '0) |=> (out_valid ##1 !out_valid));

    assert_drop_mode_R9: assert property (@(posedge clk) disable iff (rst)
        (accept && !mode_supported(job.mode)) |=> !out_valid);

endmodule

// File: rtl/irq_dispatch_top.sv
module irq_dispatch_top
    import irq_route_pkg::*;
#(
    parameter int NCPU = 8,
    localparam int IDX_W = $clog2(NCPU)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [7:0]             req_dest,
    input  logic                   req_logical,
    input  logic [2:0]             req_mode,
    input  logic [7:0]             req_vector,
    input  logic [NCPU-1:0]        cpu_present,
    input  logic [NCPU*8-1:0]      cpu_phys_id,
    input  logic [NCPU*8-1:0]      cpu_log_id,
    output logic                   out_valid,
    output logic [IDX_W-1:0]       out_target,
    output logic [7:0]             out_vector
);

    logic [NCPU-1:0]  mask;
    logic [IDX_W-1:0] last;
    logic [IDX_W-1:0] pick;
    logic             pick_ok;
    logic             accept;
    job_t             job;
    addr_kind_e       kind;

    assign kind       = req_logical ? ADDR_LOGIC : ADDR_PHYS;
    assign job.vector = req_vector;
    assign job.mode   = req_mode;
    assign accept     = req_valid && req_ready;

    irq_dest_resolve #(.NCPU(NCPU)) u_resolve (
        .dest     (req_dest),
        .kind     (kind),
        .present  (cpu_present),
        .phys_ids (cpu_phys_id),
        .log_ids  (cpu_log_id),
        .mask     (mask)
    );

    irq_rr_pick #(.NCPU(NCPU)) u_rr (
        .mask    (mask),
        .last    (last),
        .pick    (pick),
        .pick_ok (pick_ok)
    );

    irq_dispatch_seq #(.NCPU(NCPU)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .job        (job),
        .mask       (mask),
        .pick       (pick),
        .pick_ok    (pick_ok),
        .last       (last),
        .ready      (req_ready),
        .out_valid  (out_valid),
        .out_target (out_target),
        .out_vector (out_vector)
    );

    assert_phys_single_R3: assert property (@(posedge clk) disable iff (rst)
        (!req_logical && req_dest != DEST_ALL) |-> $onehot0(mask));

    assert_logic_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (accept && req_logical && req_dest == '0) |=> !out_valid);

    assert_broadcast_R2: assert property (@(posedge clk) disable iff (rst)
        (accept && req_mode == MODE_FIXED && !req_logical && req_dest == DEST_ALL
         && cpu_present != '0) |=> out_valid);

    assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(req_ready)) |-> $stable(out_vector));

endmodule

// File: tb/irq_dispatch_top_test.sv
`timescale 1ns/1ps
module irq_dispatch_top_test;

    localparam int NCPU  = 8;
    localparam int IDX_W = $clog2(NCPU);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [7:0]        req_dest = '0;
    logic              req_logical = 1'b0;
    logic [2:0]        req_mode = '0;
    logic [7:0]        req_vector = '0;
    logic [NCPU-1:0]   cpu_present = '0;
    logic [NCPU*8-1:0] cpu_phys_id = '0;
    logic [NCPU*8-1:0] cpu_log_id = '0;
    logic              out_valid;
    logic [IDX_W-1:0]  out_target;
    logic [7:0]        out_vector;

    always #2.5 clk = ~clk;

    irq_dispatch_top #(.NCPU(NCPU)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_dest(req_dest), .req_logical(req_logical), .req_mode(req_mode),
        .req_vector(req_vector), .cpu_present(cpu_present),
        .cpu_phys_id(cpu_phys_id), .cpu_log_id(cpu_log_id),
        .out_valid(out_valid), .out_target(out_target), .out_vector(out_vector)
    );

    int checks = 0;
    int fails  = 0;
    int rr_last = NCPU - 1;
    bit finished = 1'b0;
    logic [7:0] phys [NCPU];
    logic [7:0] logi [NCPU];

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic pack_ids();
        for (int i = 0; i < NCPU; i++) begin
            cpu_phys_id[i*8 +: 8] = phys[i];
            cpu_log_id[i*8 +: 8]  = logi[i];
        end
    endtask

    function automatic logic [NCPU-1:0] model_mask(input logic [7:0] d, input bit lg);
        logic [NCPU-1:0] m = '0;
        if (!lg) begin
            if (d == 8'hFF) m = cpu_present;
            else begin
                for (int i = 0; i < NCPU; i++)
                    if (m == '0 && cpu_present[i] && phys[i] == d) m[i] = 1'b1;
            end
        end else if (d != 0) begin
            for (int i = 0; i < NCPU; i++)
                if (cpu_present[i] && (logi[i] & d) != 0) m[i] = 1'b1;
        end
        return m;
    endfunction

    task automatic run_req(input logic [7:0] d, input bit lg, input logic [2:0] md,
                           input logic [7:0] v, input bit hold);
        logic [NCPU-1:0] m;
        int exp_t[NCPU];
        int exp_n = 0;
        int got = 0;
        string tag;
        m = model_mask(d, lg);
        if (md == 3'b000) begin
            for (int i = 0; i < NCPU; i++) if (m[i]) begin exp_t[exp_n] = i; exp_n++; end
        end else if (md == 3'b001 && m != '0) begin
            for (int off = 1; off <= NCPU; off++) begin
                int j = (rr_last + off) % NCPU;
                if (exp_n == 0 && m[j]) begin exp_t[0] = j; exp_n = 1; end
            end
            rr_last = exp_t[0];
        end
        if (md != 3'b000 && md != 3'b001) tag = "R9";
        else if (m == '0) tag = (lg && d == 0) ? "R4" : "R6";
        else if (md == 3'b001) tag = "R8";
        else if (!lg && d == 8'hFF) tag = "R2";
        else if (!lg) tag = "R3";
        else tag = "R5";

        @(negedge clk);
        req_dest = d; req_logical = lg; req_mode = md; req_vector = v; req_valid = 1'b1;
        chk(req_ready === 1'b1, "R10", "ready before request", int'(req_ready), 1);
        @(negedge clk);
        if (!hold || exp_n == 0) req_valid = 1'b0;
        else begin
            req_dest = 8'hFF; req_logical = 1'b0; req_mode = 3'b000; req_vector = ~v;
        end
        if (exp_n == 0)
            chk(req_ready === 1'b1, tag, "ready after empty request", int'(req_ready), 1);
        for (int c = 0; c < NCPU + 3; c++) begin
            if (out_valid !== 1'b1) break;
            if (got < exp_n) begin
                chk(int'(out_target) == exp_t[got], tag, "target", int'(out_target), exp_t[got]);
                chk(out_vector == v, "R7", "vector", int'(out_vector), int'(v));
            end
            chk(req_ready === 1'b0, "R10", "ready while busy", int'(req_ready), 0);
            got++;
            if (got >= exp_n) req_valid = 1'b0;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(got == exp_n, tag, "delivery count", got, exp_n);
        @(negedge clk);
        chk(out_valid === 1'b0, "R10", "no delivery after burst", int'(out_valid), 0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < NCPU; i++) begin phys[i] = 8'(i); logi[i] = 8'(1 << i); end
        cpu_present = '1;
        pack_ids();
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid === 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        chk(req_ready === 1'b1, "R1", "ready after reset", int'(req_ready), 1);

        // R8: first lowest-priority pick starts at index 0, then rotates and wraps
        cpu_present = 8'b1000_0101;
        run_req(8'hFF, 1'b0, 3'b001, 8'h41, 1'b0);
        run_req(8'hFF, 1'b0, 3'b001, 8'h42, 1'b0);
        run_req(8'hFF, 1'b0, 3'b001, 8'h43, 1'b0);
        run_req(8'hFF, 1'b0, 3'b001, 8'h44, 1'b0);
        // R2: broadcast over sparse present set, held requests ignored (R10)
        cpu_present = 8'b1010_0101;
        run_req(8'hFF, 1'b0, 3'b000, 8'h20, 1'b1);
        // R3: duplicate physical ID, lowest index wins
        cpu_present = '1;
        phys[5] = 8'd2;
        pack_ids();
        run_req(8'd2, 1'b0, 3'b000, 8'h30, 1'b0);
        // R3: duplicate with lower one absent
        cpu_present[2] = 1'b0;
        run_req(8'd2, 1'b0, 3'b000, 8'h31, 1'b0);
        cpu_present = '1;
        // R6: no physical match
        run_req(8'd77, 1'b0, 3'b000, 8'h32, 1'b0);
        // R4: logical zero
        run_req(8'h00, 1'b1, 3'b000, 8'h33, 1'b0);
        // R5: logical overlap
        run_req(8'h06, 1'b1, 3'b000, 8'h34, 1'b1);
        // R9: unsupported modes
        run_req(8'hFF, 1'b0, 3'b010, 8'h35, 1'b0);
        run_req(8'hFF, 1'b0, 3'b111, 8'h36, 1'b0);
        // R8: pointer untouched by fixed traffic
        run_req(8'hFF, 1'b0, 3'b001, 8'h37, 1'b0);

        for (int n = 0; n < 300; n++) begin
            logic [7:0] d;
            bit lg;
            logic [2:0] md;
            bit ok_hold;
            if (n % 10 == 0) begin
                cpu_present = NCPU'($urandom);
                for (int i = 0; i < NCPU; i++) begin
                    phys[i] = 8'($urandom % 4);
                    logi[i] = 8'($urandom);
                end
                pack_ids();
            end
            lg = 1'($urandom);
            case ($urandom % 4)
                0: d = 8'hFF;
                1: d = 8'h00;
                default: d = lg ? 8'($urandom) : 8'($urandom % 5);
            endcase
            case ($urandom % 8)
                0: md = 3'($urandom);
                1, 2, 3: md = 3'b001;
                default: md = 3'b000;
            endcase
            ok_hold = 1'($urandom);
            run_req(d, lg, md, 8'($urandom), ok_hold);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule